// File: doc/BRIEF.md
# Pin-Multiplexed Complex Sample Assembler

This block rebuilds 12-bit complex baseband samples that reach the chip over a narrow parallel bus. On every clock an enable input decides whether the bus is sampled. A two-bit mode input sets how many bus bits each transfer carries. A word can come as one full 12-bit transfer, as two 6-bit slices, or as four 3-bit slices. Slices arrive most significant first, and each one is shifted into the word from the low end.

Completed words alternate between in-phase and quadrature. The first word after an idle gap is always the in-phase word. When the quadrature word of a pair completes, both words are presented together. A one-cycle pair-valid pulse marks them, so pairs appear at half the word rate. While enable is low the block drops any partial word and any lone in-phase word. It also takes the mode input as the new active mode during that time. A mode change therefore never splits a word.

The pairing controller has three states. `ST_HALT` holds after reset and on every cycle with enable low. `ST_WANT_I` means an in-phase word is being gathered. `ST_WANT_Q` means a quadrature word is being gathered. The transitions are:
- any state to `ST_HALT` when enable is low;
- `ST_HALT` to `ST_WANT_Q` or to `ST_WANT_I` on an accepted transfer, depending on whether that transfer completes a word;
- `ST_WANT_I` to `ST_WANT_Q` when the in-phase word completes;
- `ST_WANT_Q` to `ST_WANT_I` when the quadrature word completes and the pair is emitted.

Top module: `cplx_slice_assembler`

## Requirements
- R1: During and after reset, `pair_vld`, `i_word` and `q_word` are 0, and the active mode is full-width.
- R2: Mode code 00 is full-width mode. Each accepted transfer is one whole word from `bus_in[11:0]`. Words alternate I then Q. `pair_vld` rises in the cycle after the clock edge that accepted the Q transfer.
- R3: Mode code 01 is 6-bit mode. A word is two transfers taken from `bus_in[5:0]`, and the first transfer becomes bits 11:6.
- R4: Mode code 10 is 3-bit mode. A word is four transfers taken from `bus_in[2:0]`, and the first transfer becomes bits 11:9.
- R5: A cycle with `en` low accepts nothing. It discards any partial word and any unpaired I word, so the next accepted transfer is slice zero of a new I word.
- R6: `pair_vld` is high for exactly one cycle per pair, and `i_word`/`q_word` hold their values until the next pair.
- R7: The mode input is sampled into the active mode only on cycles with `en` low. Changes while `en` is high have no effect on the words being gathered. Mode code 11 behaves as full-width.
- R8: In the split modes, bus bits above the slice width are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Accept the bus on this clock; low means idle and resynchronise |
| mode | input | 2 | Bus slicing code: 00 full, 01 6-bit, 10 3-bit, 11 full |
| bus_in | input | 12 | Transfer data; the low bits carry the slice in the split modes |
| i_word | output | 12 | In-phase word of the latest pair |
| q_word | output | 12 | Quadrature word of the latest pair |
| pair_vld | output | 1 | One-cycle strobe marking a new pair |

## Verification
The hardest case to reach from the ports is an enable drop in the middle of a quadrature word, combined with a mode change in the same idle cycle. The next accepted transfer must then restart an I word in the new slicing. To reach it, the stimulus uses a long run of random enable gaps with a mode input that changes every cycle. A behavioural queue model, compared every cycle, tracks the slices collected, the pairing phase and the latched mode. Directed sequences with literal expected words confirm slice order, the rejection of mode changes while enabled, and that upper bus bits have no effect.

// File: rtl/asm_pkg.sv
package asm_pkg;
    typedef enum logic [1:0] {
        MD_FULL     = 2'b00,
        MD_HALF     = 2'b01,
        MD_QUART    = 2'b10,
        MD_FULL_ALT = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_HALT   = 2'b00,
        ST_WANT_I = 2'b01,
        ST_WANT_Q = 2'b10
    } pair_state_e;

    localparam int SLICE_CNT_W = 2;
endpackage

// File: rtl/asm_mode_latch.sv
module asm_mode_latch
    import asm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] mode_in,
    output bus_mode_e  act_mode
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= MD_FULL;
        end else if (!en) begin
            act_mode <= bus_mode_e'(mode_in);
        end
    end
endmodule

// File: rtl/asm_slice_shift.sv
module asm_slice_shift
    import asm_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  bus_mode_e         act_mode,
    input  logic [WORD_W-1:0] bus_in,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);
    localparam int HALF_W  = WORD_W / 2;
    localparam int QUART_W = WORD_W / 4;

    logic [SLICE_CNT_W-1:0] cnt;
    logic [SLICE_CNT_W-1:0] last_idx;
    logic [WORD_W-1:0]      acc;
    logic [WORD_W-1:0]      acc_nxt;

    always_comb begin
        unique case (act_mode)
            MD_HALF: begin
                last_idx = SLICE_CNT_W'(1);
                acc_nxt  = {acc[WORD_W-HALF_W-1:0], bus_in[HALF_W-1:0]};
            end
            MD_QUART: begin
                last_idx = SLICE_CNT_W'(3);
                acc_nxt  = {acc[WORD_W-QUART_W-1:0], bus_in[QUART_W-1:0]};
            end
            MD_FULL, MD_FULL_ALT: begin
                last_idx = '0;
                acc_nxt  = bus_in;
            end
            default: begin
                last_idx = '0;
                acc_nxt  = bus_in;
            end
        endcase
    end

    assign word_done = en && (cnt == last_idx);
    assign word      = acc_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            acc <= '0;
        end else begin
            acc <= acc_nxt;
            cnt <= word_done ? '0 : cnt + SLICE_CNT_W'(1);
        end
    end
endmodule

// File: rtl/asm_pair_fsm.sv
module asm_pair_fsm
    import asm_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] i_word,
    output logic [WORD_W-1:0] q_word,
    output logic              pair_vld
);
    pair_state_e       state, state_nxt;
    logic [WORD_W-1:0] i_hold;
    logic              take_i, take_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (!en) begin
            state_nxt = ST_HALT;
        end else begin
            unique case (state)
                ST_HALT, ST_WANT_I: state_nxt = word_done ? ST_WANT_Q : ST_WANT_I;
                ST_WANT_Q:          state_nxt = word_done ? ST_WANT_I : ST_WANT_Q;
                default:            state_nxt = ST_HALT;
            endcase
        end
    end

    assign take_i = word_done && (state != ST_WANT_Q);
    assign take_q = word_done && (state == ST_WANT_Q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_hold   <= '0;
            i_word   <= '0;
            q_word   <= '0;
            pair_vld <= 1'b0;
        end else begin
            pair_vld <= take_q;
            if (take_i) i_hold <= word;
            if (take_q) begin
                i_word <= i_hold;
                q_word <= word;
            end
        end
    end
endmodule

// File: rtl/cplx_slice_assembler.sv
module cplx_slice_assembler
    import asm_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [WORD_W-1:0] bus_in,
    output logic [WORD_W-1:0] i_word,
    output logic [WORD_W-1:0] q_word,
    output logic              pair_vld
);
    bus_mode_e         act_mode;
    logic              word_done;
    logic [WORD_W-1:0] word;

    asm_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode_in  (mode),
        .act_mode (act_mode)
    );

    asm_slice_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .act_mode  (act_mode),
        .bus_in    (bus_in),
        .word_done (word_done),
        .word      (word)
    );

    asm_pair_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .word_done (word_done),
        .word      (word),
        .i_word    (i_word),
        .q_word    (q_word),
        .pair_vld  (pair_vld)
    );
endmodule

// File: rtl/asm_checker.sv
module asm_checker #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [1:0]        act_mode,
    input logic [WORD_W-1:0] i_word,
    input logic [WORD_W-1:0] q_word,
    input logic              pair_vld
);
    // R6: strobe lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |=> !pair_vld);

    // R6: outputs hold between pairs
    a_r6_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_vld |-> ($stable(i_word) && $stable(q_word)));

    // R5: an idle cycle completes nothing
    a_r5_idle_no_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pair_vld);

    // R5: first transfer after a gap can only start an I word
    a_r5_fresh_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(!en)) |=> !pair_vld);

    // R2: a pair follows an accepted transfer
    a_r2_pair_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |-> $past(en));

    // R7: active mode frozen while enabled
    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> $stable(act_mode));
endmodule

bind cplx_slice_assembler asm_checker #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .act_mode (act_mode),
    .i_word   (i_word),
    .q_word   (q_word),
    .pair_vld (pair_vld)
);

// File: tb/test_cplx_slice_assembler.sv
module test_cplx_slice_assembler;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         en;
    logic [1:0]   mode;
    logic [W-1:0] bus_in;
    logic [W-1:0] i_word, q_word;
    logic         pair_vld;

    always #5 clk = ~clk;

    cplx_slice_assembler #(.WORD_W(W)) i_cplx_slice_assembler (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .bus_in(bus_in),
        .i_word(i_word), .q_word(q_word), .pair_vld(pair_vld)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    string req    = "R1";

    // behavioural reference state
    int           m_mode  = 0;
    int           m_phase = 0;
    logic [W-1:0] m_ih    = '0;
    logic [W-1:0] m_i     = '0;
    logic [W-1:0] m_q     = '0;
    bit           m_vld   = 1'b0;
    logic [W-1:0] slices[$];

    task automatic report(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        checks++;
        if (pair_vld !== m_vld || i_word !== m_i || q_word !== m_q) begin
            errors++;
            $display("FAIL %s model actual vld=%0b i=%0h q=%0h expected vld=%0b i=%0h q=%0h",
                     req, pair_vld, i_word, q_word, m_vld, m_i, m_q);
        end
    endtask

    task automatic model(bit e, logic [1:0] m, logic [W-1:0] b);
        int n;
        int sw;
        logic [W-1:0] w;
        m_vld = 1'b0;
        if (!e) begin
            slices.delete();
            m_phase = 0;
            m_mode  = int'(m);
        end else begin
            n  = (m_mode == 1) ? 2 : (m_mode == 2) ? 4 : 1;
            sw = W / n;
            slices.push_back(b & ((W'(1) << sw) - W'(1)) | ((n == 1) ? b : '0));
            if (slices.size() == n) begin
                w = '0;
                foreach (slices[k]) w = (w << sw) | slices[k];
                slices.delete();
                if (m_phase == 0) begin
                    m_ih = w; m_phase = 1;
                end else begin
                    m_i = m_ih; m_q = w; m_vld = 1'b1; m_phase = 0;
                end
            end
        end
    endtask

    task automatic step(bit e, logic [1:0] m, logic [W-1:0] b);
        @(negedge clk);
        compare();
        en = e; mode = m; bus_in = b;
        model(e, m, b);
    endtask

    task automatic expect_pair(string tag, logic [W-1:0] ei, logic [W-1:0] eq);
        report(tag, "pair_vld", int'(pair_vld), 1);
        report(tag, "i_word", int'(i_word), int'(ei));
        report(tag, "q_word", int'(q_word), int'(eq));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; mode = 2'b00; bus_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        req = "R1";
        report("R1", "pair_vld in reset", int'(pair_vld), 0);
        report("R1", "i_word in reset", int'(i_word), 0);
        rst_n = 1'b1;
        step(1'b0, 2'b00, '0);

        // R2: full words, I then Q
        req = "R2";
        step(1'b1, 2'b00, 12'hABC);
        step(1'b1, 2'b00, 12'h123);
        step(1'b0, 2'b00, '0);
        expect_pair("R2", 12'hABC, 12'h123);
        // R6: strobe gone, data held
        step(1'b0, 2'b00, '0);
        report("R6", "pair_vld second cycle", int'(pair_vld), 0);
        report("R6", "i_word held", int'(i_word), 12'hABC);

        // R3 with junk upper bits (R8)
        req = "R3";
        step(1'b0, 2'b01, '0);
        step(1'b1, 2'b01, {6'h3C, 6'h2A});
        step(1'b1, 2'b01, {6'h11, 6'h15});
        step(1'b1, 2'b01, {6'h07, 6'h3F});
        step(1'b1, 2'b01, {6'h2E, 6'h00});
        step(1'b0, 2'b01, '0);
        expect_pair("R3", 12'hA95, 12'hFC0);
        report("R8", "upper bits ignored q", int'(q_word), 12'hFC0);

        // R4: 3-bit slices
        req = "R4";
        step(1'b0, 2'b10, '0);
        step(1'b1, 2'b10, 12'hFF5);
        step(1'b1, 2'b10, 12'h003);
        step(1'b1, 2'b10, 12'h807);
        step(1'b1, 2'b10, 12'h001);
        step(1'b1, 2'b10, 12'h000);
        step(1'b1, 2'b10, 12'hF07);
        step(1'b1, 2'b10, 12'h000);
        step(1'b1, 2'b10, 12'h007);
        step(1'b0, 2'b00, '0);
        expect_pair("R4", 12'hAF9, 12'h1C7);

        // R5: lone I discarded by an idle cycle
        req = "R5";
        step(1'b1, 2'b00, 12'h111);
        step(1'b0, 2'b00, '0);
        step(1'b1, 2'b00, 12'h222);
        step(1'b1, 2'b00, 12'h333);
        step(1'b0, 2'b00, '0);
        expect_pair("R5", 12'h222, 12'h333);

        // R7: mode input changes while enabled are ignored
        req = "R7";
        step(1'b1, 2'b10, 12'h444);
        step(1'b1, 2'b01, 12'h555);
        step(1'b0, 2'b11, '0);
        expect_pair("R7", 12'h444, 12'h555);
        step(1'b1, 2'b10, 12'h666);
        step(1'b1, 2'b10, 12'h777);
        step(1'b0, 2'b00, '0);
        expect_pair("R7", 12'h666, 12'h777);

        // random mixture: gaps, mode churn, all slicings
        req = "R5";
        for (int c = 0; c < 3000; c++) begin
            step(($urandom % 8) != 0, 2'($urandom), 12'($urandom));
        end
        step(1'b0, 2'b00, '0);
        step(1'b0, 2'b00, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule